// File: doc/BRIEF.md
# Single-Cycle Bit Search Unit

This block finds a position in a 32-bit word in one clock cycle. It can look for the first set bit, the first clear bit, or the first bit whose value differs from the top bit. The scan always begins at the most significant bit and moves toward bit 0. The answer is the number of bit positions passed over before the match. When no bit matches, the answer is the word width.

Software selects the search kind by choosing which of three write addresses receives the word. The unit latches the count and the search kind on that clock edge. A read of a fourth address then returns both values. That read is combinational, so the new result is visible in the cycle that follows the write. The unit is meant as a small helper on a register bus next to a processor core, for normalisation, priority picking and run-length work.

Top module: `bit_search_unit`

## Requirements
- R1: A write to address 0 (first-one search) stores the number of bits above the highest set bit of the word: 0 for bit 31 set, 31 when only bit 0 is set.
- R2: A write to address 1 (first-zero search) stores the number of bits above the highest clear bit of the word.
- R3: A write to address 2 (change search) stores the MSB-side index of the first bit that differs from bit 31. This value lies between 1 and 31 when such a bit exists.
- R4: When no bit matches, in any of the three modes (an all-zero word for first-one, an all-ones word for first-zero, a uniform word for change), the stored count is 32.
- R5: The count and the mode code stored by a write on clock edge k can be read in the cycle immediately after edge k. The mode codes are 0 for first-one, 1 for first-zero and 2 for change.
- R6: With rdEn high and regAddr equal to 3, rdValid is 1 and rdData holds the count in bits [5:0] and the mode code in bits [9:8], with every other bit zero. In every other case rdValid is 0 and rdData is all zero.
- R7: A write to address 3 is ignored. The stored count and mode keep their values.
- R8: Reset sets the count to 32 and the mode code to 0 (first-one).
- R9: The stored count and mode stay the same in every cycle without a write to addresses 0 to 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| regAddr | input | 2 | Register address: 0 one, 1 zero, 2 change, 3 result |
| wrData | input | 32 | Word to be searched |
| rdData | output | 32 | Result readback (count and mode) |
| rdValid | output | 1 | Read of the result address is active |

## Verification
The bench goes after the ends of each scan. A word whose only match sits at bit 31 must give 0, and a word whose only match sits at bit 0 must give 31. A scan run in the wrong direction, or a count that is off by one, fails these checks at once. The no-match words for each mode must give 32. A design that wraps to 0 or saturates at 31 on these words is caught. Change mode is tried with both polarities of bit 31, so a design that compares against a fixed zero instead of the top bit is exposed. Writes to the result address and idle cycles are followed by readback, which shows a design that lets a stray strobe load the register.

// File: rtl/bsu_pkg.sv
package bsu_pkg;

  typedef enum logic [1:0] {
    MODE_ONE    = 2'd0,
    MODE_ZERO   = 2'd1,
    MODE_CHANGE = 2'd2
  } searchMode_t;

  typedef struct packed {
    logic        load;
    searchMode_t mode;
  } ctrlStrobes_t;

  localparam logic [1:0] ADDR_RESULT = 2'd3;

endpackage

// File: rtl/bsu_lzc.sv
module bsu_lzc #(
  parameter int W     = 32,
  parameter int CNT_W = $clog2(W + 1)
) (
  input  logic [W-1:0]     vec,
  output logic [CNT_W-1:0] cnt
);

  // Highest set bit wins: later loop iterations override earlier ones.
  always_comb begin
    cnt = CNT_W'(W);
    for (int i = 0; i < W; i++) begin
      if (vec[i]) cnt = CNT_W'(W - 1 - i);
    end
  end

endmodule

// File: rtl/bsu_ctrl.sv
module bsu_ctrl
  import bsu_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wrEn,
  input  logic         rdEn,
  input  logic [1:0]   regAddr,
  output ctrlStrobes_t strb,
  output searchMode_t  modeReg,
  output logic         readHit
);

  logic searchWrite;

  assign searchWrite = wrEn && (regAddr != ADDR_RESULT);
  assign strb.load   = searchWrite;
  assign strb.mode   = searchMode_t'(regAddr);
  assign readHit     = rdEn && (regAddr == ADDR_RESULT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           modeReg <= MODE_ONE;
    else if (searchWrite) modeReg <= strb.mode;
  end

  // R7: writes to the result address leave the mode untouched
  assert_result_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && regAddr == ADDR_RESULT) |=> $stable(modeReg));

  // R9: mode only moves on a search write
  assert_mode_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wrEn && regAddr != ADDR_RESULT) |=> $stable(modeReg));

endmodule

// File: rtl/bsu_datapath.sv
module bsu_datapath
  import bsu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobes_t      strb,
  input  logic [DATA_W-1:0] dataIn,
  output logic [CNT_W-1:0]  resultCnt
);

  logic [DATA_W-1:0] scanVec;
  logic [CNT_W-1:0]  scanCnt;

  always_comb begin
    unique case (strb.mode)
      MODE_ONE:    scanVec = dataIn;
      MODE_ZERO:   scanVec = ~dataIn;
      MODE_CHANGE: scanVec = dataIn ^ {DATA_W{dataIn[DATA_W-1]}};
      default:     scanVec = dataIn;
    endcase
  end

  bsu_lzc #(.W(DATA_W), .CNT_W(CNT_W)) i_lzc (
    .vec (scanVec),
    .cnt (scanCnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         resultCnt <= CNT_W'(DATA_W);
    else if (strb.load) resultCnt <= scanCnt;
  end

  // R4: result never exceeds the word width
  assert_result_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    resultCnt <= CNT_W'(DATA_W));

  // R4: an all-zero word in first-one mode yields the width
  assert_empty_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.load && strb.mode == MODE_ONE && dataIn == '0) |=> resultCnt == CNT_W'(DATA_W));

  // R3: bit 31 never differs from itself, so a change search never reports 0
  assert_change_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.load && strb.mode == MODE_CHANGE) |=> resultCnt != '0);

  // R9: result only moves on a load
  assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.load |=> $stable(resultCnt));

endmodule

// File: rtl/bit_search_unit.sv
module bit_search_unit
  import bsu_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int MODE_LSB = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  localparam int CNT_W = $clog2(DATA_W + 1);

  ctrlStrobes_t     strb;
  searchMode_t      modeReg;
  logic             readHit;
  logic [CNT_W-1:0] resultCnt;

  bsu_ctrl i_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wrEn    (wrEn),
    .rdEn    (rdEn),
    .regAddr (regAddr),
    .strb    (strb),
    .modeReg (modeReg),
    .readHit (readHit)
  );

  bsu_datapath #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_datapath (
    .clk       (clk),
    .rst_n     (rst_n),
    .strb      (strb),
    .dataIn    (wrData),
    .resultCnt (resultCnt)
  );

  always_comb begin
    rdData = '0;
    if (readHit) begin
      rdData[CNT_W-1:0]       = resultCnt;
      rdData[MODE_LSB +: 2]   = modeReg;
    end
  end
  assign rdValid = readHit;

  // R6: nothing leaks onto the read bus without a valid read
  assert_quiet_bus_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rdEn |-> (rdData == '0 && !rdValid));

endmodule

// File: tb/test_bit_search_unit.sv
module test_bit_search_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        rdValid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  bit_search_unit i_bit_search_unit (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .rdEn(rdEn),
    .regAddr(regAddr), .wrData(wrData), .rdData(rdData), .rdValid(rdValid)
  );

  function automatic int expCount(int mode, logic [31:0] w);
    logic ref31;
    ref31 = w[31];
    for (int k = 0; k < 32; k++) begin
      logic b;
      b = w[31-k];
      if (mode == 0 && b == 1'b1) return k;
      if (mode == 1 && b == 1'b0) return k;
      if (mode == 2 && b != ref31) return k;
    end
    return 32;
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic doWrite(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; regAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  // Called at a negedge; reads combinationally.
  task automatic readResult(output logic [31:0] d, output logic v);
    regAddr = 2'd3; rdEn = 1'b1;
    #1;
    d = rdData; v = rdValid;
    rdEn = 1'b0;
    #1;
  endtask

  task automatic searchAndCheck(string req, int mode, logic [31:0] w);
    logic [31:0] d; logic v;
    logic [31:0] exp;
    doWrite(2'(mode), w);
    readResult(d, v);
    exp = 32'(expCount(mode, w)) | (32'(mode) << 8);
    check(req, $sformatf("mode %0d word %h", mode, w), d, exp);
    check("R6", "rdValid on result read", {31'd0, v}, 32'd1);
  endtask

  task automatic testReset();
    logic [31:0] d; logic v;
    @(negedge clk);
    #1;
    check("R6", "rdData idle", rdData, 32'd0);
    check("R6", "rdValid idle", {31'd0, rdValid}, 32'd0);
    readResult(d, v);
    check("R8", "reset count and mode", d, 32'd32);
  endtask

  task automatic testFirstOne();
    searchAndCheck("R1", 0, 32'h8000_0000);
    searchAndCheck("R1", 0, 32'h0000_0001);
    searchAndCheck("R1", 0, 32'h0001_0000);
    searchAndCheck("R1", 0, 32'h0001_FFFF);
    searchAndCheck("R4", 0, 32'h0000_0000);
  endtask

  task automatic testFirstZero();
    searchAndCheck("R2", 1, 32'h7FFF_FFFF);
    searchAndCheck("R2", 1, 32'hFFFF_FFFE);
    searchAndCheck("R2", 1, 32'hFF00_FFFF);
    searchAndCheck("R4", 1, 32'hFFFF_FFFF);
  endtask

  task automatic testChange();
    searchAndCheck("R3", 2, 32'hC000_0000);
    searchAndCheck("R3", 2, 32'h8000_0000);
    searchAndCheck("R3", 2, 32'h3FFF_FFFF);
    searchAndCheck("R3", 2, 32'h0000_0001);
    searchAndCheck("R3", 2, 32'hFFFF_FFFE);
    searchAndCheck("R4", 2, 32'hFFFF_FFFF);
    searchAndCheck("R4", 2, 32'h0000_0000);
  endtask

  task automatic testNextCycle();
    logic [31:0] d; logic v;
    // R5: readable in the cycle straight after the write edge
    @(negedge clk);
    wrEn = 1'b1; regAddr = 2'd1; wrData = 32'hF0FF_FFFF;
    @(negedge clk);
    wrEn = 1'b0;
    readResult(d, v);
    check("R5", "result one cycle after write", d, 32'd4 | (32'd1 << 8));
  endtask

  task automatic testIgnoredWrite();
    logic [31:0] d; logic v;
    doWrite(2'd0, 32'h0000_0100);
    doWrite(2'd3, 32'h8000_0000);
    readResult(d, v);
    check("R7", "write to result address ignored", d, 32'd23);
  endtask

  task automatic testHoldAndBus();
    logic [31:0] d; logic v;
    doWrite(2'd2, 32'hFFF0_0000);
    repeat (5) @(negedge clk);
    readResult(d, v);
    check("R9", "result held while idle", d, 32'd12 | (32'd2 << 8));
    regAddr = 2'd0; rdEn = 1'b1;
    #1;
    check("R6", "read of search address gives zero", rdData, 32'd0);
    check("R6", "read of search address not valid", {31'd0, rdValid}, 32'd0);
    rdEn = 1'b0;
  endtask

  task automatic testSweep();
    logic [31:0] lfsr = 32'hACE1_2345;
    for (int n = 0; n < 30; n++) begin
      int m;
      m = n % 3;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      // thin some words out to move the match position around
      searchAndCheck(m == 0 ? "R1" : (m == 1 ? "R2" : "R3"), m,
                     lfsr >> (n % 29));
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #100_000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    testReset();
    testFirstOne();
    testFirstZero();
    testChange();
    testNextCycle();
    testIgnoredWrite();
    testHoldAndBus();
    testSweep();
    finishRun();
  end

endmodule